// File: doc/BRIEF.md
# DDS Phase Accumulator Core

This block is the phase engine of a direct digital synthesizer. Every system clock it adds a 32-bit frequency tuning word to a phase accumulator that wraps modulo 2^32. The output frequency is therefore the tuning word times the clock frequency divided by 2^32. A 14-bit phase offset is added at the top of the accumulator value. The upper 14 bits of that sum form the phase word, which is passed to a later angle-to-amplitude stage. That stage also receives a cosine/sine select flag.

A host writes shadow copies of three registers through a plain address/data/write-enable port. The registers are control, tuning word and phase offset. A rising edge on the update strobe copies all shadow registers into the active set in one cycle. The control register provides four functions:
- a held clear of the accumulator;
- a one-cycle auto-clear that fires on each update;
- a cosine/sine select;
- a memory-drive mode, in which an external memory word replaces either the tuning word or the phase offset.

The phase word is a free-running sample stream, one sample per clock, with no valid/ready handshake. The angle-to-amplitude stage must accept a sample every cycle and cannot apply back-pressure. Host writes are always accepted.

Top module: `dds_phase_core`

## Requirements
- R1: Each clock in which no clear applies, the accumulator advances by the effective tuning word, modulo 2^32.
- R2: An effective tuning word of zero leaves the accumulator, and hence the phase word, unchanged; it does not return it to zero.
- R3: While the active hold-clear bit (control bit 0) is 1, the accumulator is zero. It resumes counting from zero once an update loads a 0 into that bit.
- R4: After reset the active hold-clear bit is 1 and its shadow copy is 0, and every other register is 0. The phase word is therefore 0 until the first update, and the sine flag is 0.
- R5: A shadow write changes nothing at the outputs until an update. Only a 0-to-1 transition of the update strobe, sampled on the clock, copies shadow to active. Holding the strobe high copies once.
- R6: When an update loads an auto-clear bit (control bit 1) of 1, the accumulator is loaded with zero at that update edge only, and counts on from the next cycle.
- R7: The phase word is bits [31:18] of (accumulator + offset·2^18), where offset is the 14-bit effective phase offset. It is registered one cycle after the accumulator value it is formed from.
- R8: With memory drive on (control bit 3 = 1) and destination bit (control bit 4) = 0, the input memory word replaces the tuning word.
- R9: With memory drive on and destination bit = 1, bits [13:0] of the memory word replace the phase offset. With memory drive off, the memory word has no effect.
- R10: The sine flag output equals active control bit 2 (0 = cosine, 1 = sine).
- R11: Address 0 writes control bits [4:0], address 1 writes the tuning word, address 2 writes the offset from data bits [13:0], and address 3 is ignored.
- R12: A write in the same cycle as an update edge lands only in the shadow set. The active set receives the shadow value held before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Shadow register write enable |
| wr_addr | input | 2 | Shadow register address |
| wr_data | input | 32 | Shadow register write data |
| io_update | input | 1 | Update strobe; rising edge copies shadow to active |
| mem_word | input | 32 | External memory word for memory-drive mode |
| phase_word | output | 14 | Phase sample to the angle-to-amplitude stage |
| sine_sel | output | 1 | 1 = sine, 0 = cosine |

## Verification
A wrong active register or a missed update shows up at the phase word within two cycles of the edge. The phase word is the top of a sum that slides by the tuning word every clock, so the error then grows with every cycle. A wrong clear shows as a nonzero phase where zero was due, or as a zero where counting was due; both appear on the cycle after the accumulator edge. The auto-clear window is a single cycle, so the bench compares every cycle against an arithmetic model rather than sampling sparsely. A memory-routing fault shows as soon as the memory word differs from the programmed word.

// File: rtl/dds_core_pkg.sv
package dds_core_pkg;

  // Control register layout, bit 0 is the last member.
  typedef struct packed {
    logic mem_dest;   // bit 4: 0 = tuning word, 1 = phase offset
    logic mem_en;     // bit 3: memory word drives the core
    logic sine;       // bit 2: 1 = sine, 0 = cosine
    logic auto_clr;   // bit 1: one-cycle clear on update
    logic hold_clr;   // bit 0: hold accumulator at zero
  } dds_ctrl_t;

  localparam int CTRL_W = $bits(dds_ctrl_t);

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_FTW  = 2'd1;
  localparam logic [1:0] ADDR_OFF  = 2'd2;

  localparam dds_ctrl_t CTRL_ACT_RESET = '{mem_dest: 1'b0, mem_en: 1'b0,
                                           sine: 1'b0, auto_clr: 1'b0,
                                           hold_clr: 1'b1};
  localparam dds_ctrl_t CTRL_SHD_RESET = '0;

endpackage

// File: rtl/dds_shadow_regs.sv
module dds_shadow_regs
  import dds_core_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int OFF_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             io_update,
  output dds_ctrl_t        shd_ctrl,
  output dds_ctrl_t        act_ctrl,
  output logic [ACC_W-1:0] act_ftw,
  output logic [OFF_W-1:0] act_off,
  output logic             upd_rise
);

  logic             upd_q;
  logic [ACC_W-1:0] shd_ftw;
  logic [OFF_W-1:0] shd_off;

  logic unused_wr_hi;
  assign unused_wr_hi = ^wr_data[ACC_W-1:OFF_W];

  assign upd_rise = io_update && !upd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) upd_q <= 1'b0;
    else        upd_q <= io_update;
  end

  // Shadow set: host writes only
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shd_ctrl <= CTRL_SHD_RESET;
      shd_ftw  <= '0;
      shd_off  <= '0;
    end else if (wr_en) begin
      unique case (wr_addr)
        ADDR_CTRL: shd_ctrl <= dds_ctrl_t'(wr_data[CTRL_W-1:0]);
        ADDR_FTW:  shd_ftw  <= wr_data;
        ADDR_OFF:  shd_off  <= wr_data[OFF_W-1:0];
        default:   ;
      endcase
    end
  end

  // Active set: copied on update edge
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_ctrl <= CTRL_ACT_RESET;
      act_ftw  <= '0;
      act_off  <= '0;
    end else if (upd_rise) begin
      act_ctrl <= shd_ctrl;
      act_ftw  <= shd_ftw;
      act_off  <= shd_off;
    end
  end

  // R5
  shadow_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_rise |=> ($stable(act_ctrl) && $stable(act_ftw) && $stable(act_off)));

  // R12
  update_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_rise |=> (act_ftw == $past(shd_ftw) && act_off == $past(shd_off)));

endmodule

// File: rtl/dds_src_route.sv
module dds_src_route
  import dds_core_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int OFF_W = 14
) (
  input  dds_ctrl_t        act_ctrl,
  input  logic [ACC_W-1:0] act_ftw,
  input  logic [OFF_W-1:0] act_off,
  input  logic [ACC_W-1:0] mem_word,
  output logic [ACC_W-1:0] ftw_eff,
  output logic [OFF_W-1:0] off_eff
);

  logic mem_to_ftw;
  logic mem_to_off;

  always_comb begin
    mem_to_ftw = act_ctrl.mem_en && !act_ctrl.mem_dest;
    mem_to_off = act_ctrl.mem_en &&  act_ctrl.mem_dest;
    ftw_eff    = mem_to_ftw ? mem_word : act_ftw;
    off_eff    = mem_to_off ? mem_word[OFF_W-1:0] : act_off;
  end

endmodule

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 32,
  parameter int OFF_W = 14,
  parameter int OUT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [ACC_W-1:0] ftw,
  input  logic [OFF_W-1:0] off,
  output logic [ACC_W-1:0] acc_q,
  output logic [OUT_W-1:0] phase_q
);

  localparam int PAD_W = ACC_W - OFF_W;

  logic [ACC_W-1:0] off_ext;
  logic [ACC_W-1:0] phase_sum;

  assign off_ext   = {off, {PAD_W{1'b0}}};
  assign phase_sum = acc_q + off_ext;

  always_ff @(posedge clk) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else          acc_q <= acc_q + ftw;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_sum[ACC_W-1 -: OUT_W];
  end

  // R1
  acc_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> acc_q == $past(acc_q) + $past(ftw));

  // R2
  zero_ftw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && ftw == '0) |=> $stable(acc_q));

endmodule

// File: rtl/dds_phase_core.sv
module dds_phase_core
  import dds_core_pkg::*;
#(
  parameter int ACC_W = 32,
  parameter int OFF_W = 14,
  parameter int OUT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [ACC_W-1:0] wr_data,
  input  logic             io_update,
  input  logic [ACC_W-1:0] mem_word,
  output logic [OUT_W-1:0] phase_word,
  output logic             sine_sel
);

  dds_ctrl_t        shd_ctrl;
  dds_ctrl_t        act_ctrl;
  logic [ACC_W-1:0] act_ftw;
  logic [OFF_W-1:0] act_off;
  logic             upd_rise;
  logic [ACC_W-1:0] ftw_eff;
  logic [OFF_W-1:0] off_eff;
  logic [ACC_W-1:0] acc_q;
  logic             hold_next;
  logic             clr_next;

  dds_shadow_regs #(.ACC_W(ACC_W), .OFF_W(OFF_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .io_update (io_update),
    .shd_ctrl  (shd_ctrl),
    .act_ctrl  (act_ctrl),
    .act_ftw   (act_ftw),
    .act_off   (act_off),
    .upd_rise  (upd_rise)
  );

  dds_src_route #(.ACC_W(ACC_W), .OFF_W(OFF_W)) u_route (
    .act_ctrl (act_ctrl),
    .act_ftw  (act_ftw),
    .act_off  (act_off),
    .mem_word (mem_word),
    .ftw_eff  (ftw_eff),
    .off_eff  (off_eff)
  );

  // Clear seen by the accumulator edge: the hold bit as it will be
  // after this edge, plus the auto pulse for an update edge.
  always_comb begin
    hold_next = upd_rise ? shd_ctrl.hold_clr : act_ctrl.hold_clr;
    clr_next  = hold_next || (upd_rise && shd_ctrl.auto_clr);
  end

  dds_phase_acc #(.ACC_W(ACC_W), .OFF_W(OFF_W), .OUT_W(OUT_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_next),
    .ftw     (ftw_eff),
    .off     (off_eff),
    .acc_q   (acc_q),
    .phase_q (phase_word)
  );

  assign sine_sel = act_ctrl.sine;

  // R3
  hold_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_ctrl.hold_clr && !upd_rise) |=> acc_q == '0);

  // R6
  auto_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_rise && shd_ctrl.auto_clr) |=> acc_q == '0);

  // R10
  sine_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_rise |=> sine_sel == $past(shd_ctrl.sine));

endmodule

// File: tb/test_dds_phase_core.sv
`timescale 1ns/1ps
module test_dds_phase_core;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic        io_update;
  logic [31:0] mem_word;
  logic [13:0] phase_word;
  logic        sine_sel;

  always #2.5 clk = ~clk;

  dds_phase_core i_dds_phase_core (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .io_update(io_update), .mem_word(mem_word),
    .phase_word(phase_word), .sine_sel(sine_sel)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;
  string tag = "R4";

  // Arithmetic reference state
  logic [4:0]  ms_ctrl, ma_ctrl;
  logic [31:0] ms_ftw, ma_ftw, m_acc;
  logic [13:0] ms_off, ma_off, m_phase;
  logic        m_updq;

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic model_edge();
    logic        rise;
    logic [31:0] fe;
    logic [13:0] oe;
    logic [31:0] s;
    logic        clr;
    rise = io_update && !m_updq;
    fe   = (ma_ctrl[3] && !ma_ctrl[4]) ? mem_word : ma_ftw;
    oe   = (ma_ctrl[3] &&  ma_ctrl[4]) ? mem_word[13:0] : ma_off;
    s    = m_acc + {oe, 18'b0};
    clr  = (rise ? ms_ctrl[0] : ma_ctrl[0]) || (rise && ms_ctrl[1]);
    m_phase = s[31:18];
    m_acc   = clr ? 32'd0 : m_acc + fe;
    if (rise) begin
      ma_ctrl = ms_ctrl; ma_ftw = ms_ftw; ma_off = ms_off;
    end
    if (wr_en) begin
      case (wr_addr)
        2'd0: ms_ctrl = wr_data[4:0];
        2'd1: ms_ftw  = wr_data;
        2'd2: ms_off  = wr_data[13:0];
        default: ;
      endcase
    end
    m_updq = io_update;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk({tag, " phase"}, {18'd0, phase_word}, {18'd0, m_phase});
    chk("R10 sine", {31'd0, sine_sel}, {31'd0, ma_ctrl[2]});
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic upd();
    io_update = 1'b1;
    step();
    io_update = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [13:0] held;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    io_update = 1'b0; mem_word = '0;
    ms_ctrl = 5'd0; ma_ctrl = 5'b00001; ms_ftw = '0; ma_ftw = '0;
    ms_off = '0; ma_off = '0; m_acc = '0; m_phase = '0; m_updq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R4 reset state
    chk("R4 phase at reset", {18'd0, phase_word}, 32'd0);
    chk("R4 sine at reset", {31'd0, sine_sel}, 32'd0);

    // R5: shadow writes without update have no effect; R4 hold persists
    tag = "R5";
    wr(2'd1, 32'h0123_4567);
    wr(2'd0, 32'h0000_0004);
    wr(2'd2, 32'h0000_1555);
    run(6);
    chk("R4 still cleared", {18'd0, phase_word}, 32'd0);
    chk("R5 sine not yet", {31'd0, sine_sel}, 32'd0);

    // R1 / R7: update releases hold, accumulation with offset
    tag = "R1";
    upd();
    run(20);
    chk("R10 sine active", {31'd0, sine_sel}, 32'd1);
    // R5: strobe held high copies only once
    tag = "R5";
    wr(2'd1, 32'h1000_0000);
    io_update = 1'b1;
    run(4);
    wr(2'd1, 32'h0000_0001);
    run(4);
    io_update = 1'b0;
    run(4);

    // R2: zero tuning word holds phase
    tag = "R2";
    wr(2'd1, 32'd0);
    upd();
    run(1);
    held = phase_word;
    run(8);
    chk("R2 phase held", {18'd0, phase_word}, {18'd0, held});

    // R3: hold clear
    tag = "R3";
    wr(2'd1, 32'h0765_4321);
    wr(2'd0, 32'h0000_0001);
    upd();
    run(6);
    wr(2'd2, 32'd0);
    upd();
    run(3);
    chk("R3 held at zero", {18'd0, phase_word}, 32'd0);
    wr(2'd0, 32'h0000_0000);
    upd();
    run(10);

    // R6: auto clear, with strobe high for several cycles
    tag = "R6";
    wr(2'd0, 32'h0000_0002);
    io_update = 1'b1;
    run(4);
    io_update = 1'b0;
    run(6);
    upd();
    run(6);

    // R12: write coincident with update edge
    tag = "R12";
    wr(2'd1, 32'h0200_0000);
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = 32'h3000_0000; io_update = 1'b1;
    step();
    wr_en = 1'b0; io_update = 1'b0;
    run(6);
    upd();
    run(6);

    // R11: address 3 ignored
    tag = "R11";
    wr(2'd3, 32'hFFFF_FFFF);
    upd();
    run(6);

    // R8 / R9: memory drive routing
    tag = "R8";
    mem_word = 32'h0400_0000;
    wr(2'd0, 32'h0000_0008);
    upd();
    run(8);
    mem_word = 32'h0080_0000;
    run(8);
    tag = "R9";
    wr(2'd0, 32'h0000_0018);
    upd();
    for (int k = 0; k < 16; k++) begin
      mem_word = 32'h0000_0000 + (k * 32'h0000_0421);
      step();
    end
    wr(2'd0, 32'h0000_0000);
    upd();
    mem_word = 32'hDEAD_BEEF;
    run(8);

    // R7: sweep of control combinations, tuning words and offsets
    tag = "R7";
    for (int c = 0; c < 32; c++) begin
      for (int f = 0; f < 4; f++) begin
        wr(2'd0, c);
        wr(2'd1, (32'h0913_5A37 * (f + 1)) ^ (c << 20));
        wr(2'd2, (c * 517 + f * 3001) & 32'h3FFF);
        mem_word = 32'h00C0_FFEE * (c + f + 1);
        upd();
        run(10);
      end
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule